// File: doc/BRIEF.md
# Multi-Ratio Serial-to-Parallel Converter with Parity and Frame Marker

This block takes a serial bit stream, one bit per clock, and gathers it into parallel words. The word width is chosen at run time as 16, 10, 8 or 4 bits. Each finished word comes out on a 16-bit bus together with a one-cycle word enable and an even-parity bit.

A 16-bit header pattern is compared against every window of the most recent bits. A match marks the word in which the last header bit arrives with a one-cycle frame pulse.

When the width select changes, the bit count starts over. The first word at the new width is discarded, so downstream logic never sees a word that mixes two widths.

Top module: `deser_top`

## Requirements
- R1: `ratio_sel` picks the word width W: 2'b00 gives 16, 2'b01 gives 10, 2'b10 gives 8, 2'b11 gives 4.
- R2: `word_en` is high for exactly one clock, in the cycle after the clock edge that samples the W-th bit of a word. Outside a suppressed word, one word comes out for every W bits.
- R3: The earliest bit of a word appears at bit W-1 of `par_word`, and the latest bit appears at bit 0.
- R4: When W is less than 16, bits 15 down to W of `par_word` are zero whenever `word_en` is high.
- R5: `par_bit` is chosen so that `par_bit` together with `par_word` holds an even number of ones.
- R6: A header match occurs at an edge when the last W sampled bits equal `hdr_pat[W-1:0]`. The oldest of those bits is compared with `hdr_pat[W-1]`. At least W bits must have been sampled since reset or since the last width change. `frame_pulse` goes high with the word that contains the bit completing the match.
- R7: `frame_pulse` is high only in a cycle where `word_en` is high, and it lasts one clock.
- R8: At an edge where `ratio_sel` differs from the width in use, the new width is taken and the bit sampled at that edge is dropped. The count starts over, and the next W bits produce neither `word_en` nor `frame_pulse`.
- R9: While `rst_n` is low, `par_word`, `word_en`, `par_bit` and `frame_pulse` are all zero, and the width in use follows `ratio_sel`.
- R10: Bits of `hdr_pat` at positions W and above have no effect on `frame_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_in | input | 1 | Serial data bit |
| ratio_sel | input | 2 | Word width select |
| hdr_pat | input | 16 | Frame header pattern; low W bits are used |
| par_word | output | 16 | Parallel word, right-aligned |
| word_en | output | 1 | One-cycle word enable |
| par_bit | output | 1 | Even-parity bit for `par_word` |
| frame_pulse | output | 1 | One-cycle header-found marker |

## Verification
The assertions assume that `ratio_sel` changes only at clock edges. They also assume that every width holds for at least two clocks, so the enable spacing is never shorter than four. The upper-bit check reads the width actually in use, not the raw select, so a select that changes in the same cycle as a word enable does not trip it.

The stimulus drives `ratio_sel` and `ser_in` only at falling edges. It inserts the header into random data at offsets that drift against word boundaries. It switches widths both at word boundaries and in the middle of a word, including one width that is held for only a few clocks.

// File: rtl/deser_pkg.sv
package deser_pkg;
  localparam int MAX_W = 16;
  localparam int CNT_W = $clog2(MAX_W + 1);

  typedef enum logic [1:0] {
    RAT_16 = 2'b00,
    RAT_10 = 2'b01,
    RAT_8  = 2'b10,
    RAT_4  = 2'b11
  } ratio_e;

  // Word width for a ratio code (R1)
  function automatic logic [CNT_W-1:0] ratio_width(input logic [1:0] r);
    case (ratio_e'(r))
      RAT_16:  return CNT_W'(16);
      RAT_10:  return CNT_W'(10);
      RAT_8:   return CNT_W'(8);
      default: return CNT_W'(4);
    endcase
  endfunction

  // Ones in the low W bits
  function automatic logic [MAX_W-1:0] width_mask(input logic [1:0] r);
    logic [MAX_W:0] m;
    m = ({{MAX_W{1'b0}}, 1'b1} << ratio_width(r)) - {{MAX_W{1'b0}}, 1'b1};
    return m[MAX_W-1:0];
  endfunction

  // Bit that makes the total count of ones even
  function automatic logic even_par(input logic [MAX_W-1:0] d);
    return ^d;
  endfunction
endpackage

// File: rtl/deser_ratio_ctl.sv
module deser_ratio_ctl
  import deser_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ratio_sel,
  output logic [1:0] ratio_q,
  output logic       ratio_chg,
  output logic       last_bit,
  output logic       skip_word
);
  logic [CNT_W-1:0] cnt;

  assign ratio_chg = (ratio_sel != ratio_q);
  assign last_bit  = !ratio_chg && (cnt == ratio_width(ratio_q) - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ratio_q   <= ratio_sel;
      cnt       <= '0;
      skip_word <= 1'b0;
    end else if (ratio_chg) begin
      ratio_q   <= ratio_sel;
      cnt       <= '0;
      skip_word <= 1'b1;
    end else if (last_bit) begin
      cnt       <= '0;
      skip_word <= 1'b0;
    end else begin
      cnt       <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/deser_assemble.sv
module deser_assemble
  import deser_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_in,
  input  logic             clear,
  input  logic             emit,
  input  logic [MAX_W-1:0] mask,
  output logic [MAX_W-1:0] shift_nxt,
  output logic [MAX_W-1:0] word_q,
  output logic             vld_q,
  output logic             par_q
);
  logic [MAX_W-1:0] shreg;

  assign shift_nxt = {shreg[MAX_W-2:0], ser_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg  <= '0;
      word_q <= '0;
      vld_q  <= 1'b0;
      par_q  <= 1'b0;
    end else begin
      shreg <= clear ? '0 : shift_nxt;
      vld_q <= emit;
      if (emit) begin
        word_q <= shift_nxt & mask;
        par_q  <= even_par(shift_nxt & mask);
      end
    end
  end
endmodule

// File: rtl/deser_hdr_match.sv
module deser_hdr_match
  import deser_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             last_bit,
  input  logic             emit,
  input  logic [MAX_W-1:0] window,
  input  logic [MAX_W-1:0] hdr_pat,
  input  logic [MAX_W-1:0] mask,
  input  logic [CNT_W-1:0] width,
  output logic             match_now,
  output logic             frame_q
);
  logic [CNT_W-1:0] fill;
  logic             hit_acc;

  assign match_now = !clear && (fill >= width - CNT_W'(1)) &&
                     (((window ^ hdr_pat) & mask) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill    <= '0;
      hit_acc <= 1'b0;
      frame_q <= 1'b0;
    end else begin
      if (clear)
        fill <= '0;
      else if (fill < CNT_W'(MAX_W))
        fill <= fill + CNT_W'(1);
      if (clear || last_bit)
        hit_acc <= 1'b0;
      else
        hit_acc <= hit_acc | match_now;
      frame_q <= emit && (hit_acc || match_now);
    end
  end
endmodule

// File: rtl/deser_top.sv
module deser_top
  import deser_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_in,
  input  logic [1:0]  ratio_sel,
  input  logic [15:0] hdr_pat,
  output logic [15:0] par_word,
  output logic        word_en,
  output logic        par_bit,
  output logic        frame_pulse
);
  logic [1:0]       cur_ratio;
  logic             ratio_chg;
  logic             last_bit;
  logic             skip_word;
  logic             emit;
  logic             match_now;
  logic [MAX_W-1:0] cur_mask;
  logic [MAX_W-1:0] shift_nxt;
  logic [CNT_W-1:0] cur_width;

  assign cur_mask  = width_mask(cur_ratio);
  assign cur_width = ratio_width(cur_ratio);
  assign emit      = last_bit && !skip_word;

  deser_ratio_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ratio_sel (ratio_sel),
    .ratio_q   (cur_ratio),
    .ratio_chg (ratio_chg),
    .last_bit  (last_bit),
    .skip_word (skip_word)
  );

  deser_assemble u_asm (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_in    (ser_in),
    .clear     (ratio_chg),
    .emit      (emit),
    .mask      (cur_mask),
    .shift_nxt (shift_nxt),
    .word_q    (par_word),
    .vld_q     (word_en),
    .par_q     (par_bit)
  );

  deser_hdr_match u_hdr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (ratio_chg),
    .last_bit  (last_bit),
    .emit      (emit),
    .window    (shift_nxt),
    .hdr_pat   (hdr_pat),
    .mask      (cur_mask),
    .width     (cur_width),
    .match_now (match_now),
    .frame_q   (frame_pulse)
  );
endmodule

// File: rtl/deser_chk.sv
module deser_chk
  import deser_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] par_word,
  input logic        word_en,
  input logic        par_bit,
  input logic        frame_pulse,
  input logic [1:0]  cur_ratio,
  input logic        ratio_chg
);
  // R7
  fp_needs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |-> word_en);

  // R2
  en_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_en |=> !word_en);

  // R5
  parity_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_en |-> ($countones({par_bit, par_word}) % 2 == 0));

  // R4
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_en |-> ((par_word & ~width_mask(cur_ratio)) == '0));

  // R8
  chg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_chg |=> (!word_en && !frame_pulse));
endmodule

bind deser_top deser_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .par_word    (par_word),
  .word_en     (word_en),
  .par_bit     (par_bit),
  .frame_pulse (frame_pulse),
  .cur_ratio   (cur_ratio),
  .ratio_chg   (ratio_chg)
);

// File: tb/deser_top_test.sv
module deser_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ser_in;
  logic [1:0]  ratio_sel;
  logic [15:0] hdr_pat;
  logic [15:0] par_word;
  logic        word_en;
  logic        par_bit;
  logic        frame_pulse;

  int total = 0;
  int bad = 0;
  int fp_seen = 0;

  // Reference model state
  bit          hist[$];
  int          m_cnt;
  bit          m_skip;
  bit          m_hit;
  logic [1:0]  m_ratio;
  bit          exp_en;
  bit          exp_fp;
  bit          exp_par;
  logic [15:0] exp_word;

  always #(CLK_PERIOD/2) clk = ~clk;

  deser_top uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_in      (ser_in),
    .ratio_sel   (ratio_sel),
    .hdr_pat     (hdr_pat),
    .par_word    (par_word),
    .word_en     (word_en),
    .par_bit     (par_bit),
    .frame_pulse (frame_pulse)
  );

  function automatic int wid(input logic [1:0] r);
    case (r)
      2'b00:   return 16;
      2'b01:   return 10;
      2'b10:   return 8;
      default: return 4;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step(input bit b, input logic [1:0] r);
    int w;
    bit match;
    if (r != m_ratio) begin
      m_ratio = r;
      hist.delete();
      m_cnt = 0;
      m_skip = 1;
      m_hit = 0;
      exp_en = 0;
      exp_fp = 0;
      return;
    end
    w = wid(m_ratio);
    hist.push_back(b);
    if (hist.size() > 16) void'(hist.pop_front());
    match = (hist.size() >= w);
    for (int i = 0; i < w && match; i++)
      if (hist[hist.size() - w + i] != hdr_pat[w-1-i]) match = 0;
    m_hit = m_hit | match;
    m_cnt++;
    exp_en = 0;
    exp_fp = 0;
    if (m_cnt == w) begin
      m_cnt = 0;
      if (m_skip) begin
        m_skip = 0;
      end else begin
        int ones = 0;
        exp_en = 1;
        exp_fp = m_hit;
        exp_word = '0;
        for (int i = 0; i < w; i++) begin
          exp_word[w-1-i] = hist[hist.size() - w + i];
          if (hist[hist.size() - w + i]) ones++;
        end
        exp_par = ones[0];
      end
      m_hit = 0;
    end
  endtask

  task automatic cycle(input bit b, input logic [1:0] r);
    ser_in = b;
    ratio_sel = r;
    @(posedge clk);
    model_step(b, r);
    @(negedge clk);
    // R1 R2 R8: enable timing per width, suppression after change
    check(word_en == exp_en, "R1 R2 R8 word_en", word_en, exp_en);
    // R6 R7 R10: frame pulse placement
    check(frame_pulse == exp_fp, "R6 R7 R10 frame_pulse", frame_pulse, exp_fp);
    if (frame_pulse) fp_seen++;
    if (exp_en) begin
      // R3 R4: bit order and zeroed upper bits
      check(par_word == exp_word, "R3 R4 par_word", par_word, exp_word);
      // R5: even parity
      check(par_bit == exp_par, "R5 par_bit", par_bit, exp_par);
    end
  endtask

  task automatic run(input logic [1:0] r, input int n);
    int w = wid(r);
    for (int k = 0; k < n; k++) begin
      if (k % 29 == 5) begin
        for (int i = w - 1; i >= 0; i--) cycle(hdr_pat[i], r);
      end else begin
        cycle(1'($urandom % 2), r);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ser_in = 1'b0;
    ratio_sel = 2'b00;
    hdr_pat = 16'hF0B9;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(par_word == 16'h0, "R9 par_word", par_word, 0);
    check(word_en == 1'b0, "R9 word_en", word_en, 0);
    check(par_bit == 1'b0, "R9 par_bit", par_bit, 0);
    check(frame_pulse == 1'b0, "R9 frame_pulse", frame_pulse, 0);
    rst_n = 1'b1;
    m_ratio = 2'b00;
    m_cnt = 0;
    m_skip = 0;
    m_hit = 0;
    exp_en = 0;
    exp_fp = 0;
    hist.delete();

    run(2'b00, 300);
    run(2'b01, 300);
    run(2'b10, 300);
    run(2'b11, 300);
    // mid-word change and a very short-lived width
    for (int i = 0; i < 7; i++) cycle(1'($urandom % 2), 2'b01);
    for (int i = 0; i < 3; i++) cycle(1'($urandom % 2), 2'b10);
    run(2'b00, 200);
    hdr_pat = 16'h2A63;
    run(2'b11, 200);
    run(2'b01, 200);

    // R6: header occurrences were flagged
    check(fp_seen > 0, "R6 frame pulses seen", fp_seen, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule